// File: doc/BRIEF.md
# Serial Receiver with Selectable Word Length

This block turns an asynchronous serial line into parallel words. It watches the line through a two-stage synchronizer and times every bit with a strobe that pulses sixteen times per bit period. A falling edge that is still low at the middle of the bit starts a frame. The block then collects five to eight data bits, least significant bit first. A parity bit follows when parity is enabled, and then the stop bit. Each bit value is decided by a majority of three samples taken around the centre of the bit.

At the centre of the first stop bit, the assembled word moves into a one-entry receive buffer, together with a frame-error flag and a parity-error flag. A ready flag is set at the same time. The surrounding logic reads the word through a strobe, which clears the ready flag. Data bits above the configured word length always read as zero. While the enable input is low, the receiver ignores the line and leaves the buffer alone.

Top module: `uart_rx_varlen`

## Requirements
- R1: `rx_line` passes through two flip-flops before it is used. While idle and enabled, a strobe that sees the synchronized line low starts a frame. If the majority of the samples at strobes 7, 8 and 9 (the detecting strobe is strobe 0) reads high, the start is discarded and nothing is loaded.
- R2: Data bits arrive least significant bit first. The number of data bits is `word_len` + 5, so codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits.
- R3: Each bit's value is the majority of the synchronized line at strobes 7, 8 and 9 of that bit. A single disagreeing sample does not change the value.
- R4: With `parity_en` high, one parity bit follows the data. With `parity_odd` low, the data bits plus the parity bit must hold an even number of ones; with it high, an odd number. A mismatch sets `err_parity` with the loaded word. With `parity_en` low, `err_parity` is loaded as 0.
- R5: A first stop bit that samples low sets `err_frame`. The word is still loaded.
- R6: The buffer, both error flags and `rx_ready` update at the clock edge of strobe 16*(1+N+P)+9, counted from the detecting strobe. N is the number of data bits and P is 1 when parity is enabled. No second stop bit is checked, and a new start bit may follow the first stop bit directly. Outputs change only at strobe edges.
- R7: In `rd_data`, bits at positions N and above are zero.
- R8: A clock edge with `rd_stb` high clears `rx_ready`, unless a word is loaded on the same edge, in which case `rx_ready` stays high. A read leaves `rd_data` and the error flags unchanged.
- R9: While `rx_en` is low, no frame is detected and any frame in progress is dropped. `rd_data`, `rx_ready` and the error flags keep their values.
- R10: After reset, `rx_ready`, `err_frame` and `err_parity` are 0 and `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rx_line | input | 1 | Serial input, idle high |
| os_tick | input | 1 | Oversampling strobe, 16 pulses per bit |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_stb | input | 1 | Read strobe, clears the ready flag |
| rd_data | output | 8 | Buffered word, unused upper bits zero |
| rx_ready | output | 1 | A loaded word has not yet been read |
| err_frame | output | 1 | Stop bit of the buffered word was low |
| err_parity | output | 1 | Parity of the buffered word did not match |

## Verification
The hardest cases to reach are the ones that depend on one particular oversampling strobe. Examples are a read strobe that lands on the same edge as a load, a single flipped sample at a bit centre, and a low pulse that ends before the start-bit check. The bench drives the line as a queue of one-strobe segments, each starting just after a strobe edge. This gives it control of every sample, so it can shorten a start bit, flip one centre sample or place frames back to back. Its model converts the start of each frame into the index of its completion strobe, and the read strobe can be tied to that exact edge.

// File: rtl/uart_rxv_pkg.sv
// Shared types and helpers for the variable-length serial receiver.
// Assumes: nothing beyond standard SystemVerilog.
package uart_rxv_pkg;

    // Frame phase of the receiver controller
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_phase_t;

    // Two-out-of-three majority
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxv_line_sync.sv
// Brings the asynchronous serial line into the clock domain.
// Assumes: STAGES >= 2; the line idles high, so reset loads ones.
module rxv_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe;

    // Shift the line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/rxv_bit_timer.sv
// Counts oversampling strobes within one bit and votes on the bit value.
// Assumes: run is high from the detecting strobe onward; the detecting
// strobe is position 0, and the samples are taken at MID-1, MID and MID+1.
module rxv_bit_timer
    import uart_rxv_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic line,
    output logic decide,
    output logic bit_end,
    output logic bit_val
);

    localparam int CW  = $clog2(OVERSAMPLE);
    localparam int MID = OVERSAMPLE / 2;

    logic [CW-1:0] cnt;
    logic          smp_early;
    logic          smp_centre;

    // Strobe position within the current bit, held at zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= (cnt == CW'(OVERSAMPLE - 1)) ? '0 : cnt + 1'b1;
    end

    // Capture the two samples that precede the deciding strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_early  <= 1'b1;
            smp_centre <= 1'b1;
        end else if (run && tick) begin
            if (cnt == CW'(MID - 1)) smp_early  <= line;
            if (cnt == CW'(MID))     smp_centre <= line;
        end
    end

    assign decide  = run && tick && (cnt == CW'(MID + 1));
    assign bit_end = run && tick && (cnt == CW'(OVERSAMPLE - 1));
    assign bit_val = vote3(smp_early, smp_centre, line);

endmodule

// File: rtl/rxv_frame_ctrl.sv
// Walks a frame: start check, data shift, optional parity, first stop bit.
// Assumes: decide and bit_end never fire on the same strobe; word_len and
// the parity settings stay stable while a frame is in progress.
module rxv_frame_ctrl
    import uart_rxv_pkg::*;
#(
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    enable,
    input  logic                                    tick,
    input  logic                                    line,
    input  logic [$clog2(MAX_BITS-MIN_BITS+1)-1:0]  word_len,
    input  logic                                    parity_en,
    input  logic                                    parity_odd,
    input  logic                                    decide,
    input  logic                                    bit_end,
    input  logic                                    bit_val,
    output logic                                    timer_run,
    output logic                                    busy,
    output logic                                    done,
    output logic [MAX_BITS-1:0]                     done_data,
    output logic                                    done_ferr,
    output logic                                    done_perr
);

    localparam int IW = $clog2(MAX_BITS);
    localparam int SW = $clog2(MAX_BITS + 1);

    rx_phase_t         state;
    logic [MAX_BITS-1:0] shreg;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     last_idx;
    logic [SW-1:0]     shift_amt;
    logic              par_acc;
    logic              par_bit;
    logic              detect;

    assign last_idx  = IW'(word_len) + IW'(MIN_BITS - 1);
    assign shift_amt = SW'(MAX_BITS - 1) - SW'(last_idx);
    assign detect    = enable && (state == RX_IDLE) && tick && !line;
    assign timer_run = (enable && (state != RX_IDLE)) || detect;
    assign busy      = (state != RX_IDLE);

    // Frame sequencing, data shifting and parity accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            shreg   <= '0;
            idx     <= '0;
            par_acc <= 1'b0;
            par_bit <= 1'b0;
        end else if (!enable) begin
            state <= RX_IDLE;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (detect) state <= RX_START;
                end
                RX_START: begin
                    if (decide && bit_val) begin
                        state <= RX_IDLE;
                    end else if (bit_end) begin
                        state   <= RX_DATA;
                        idx     <= '0;
                        par_acc <= 1'b0;
                    end
                end
                RX_DATA: begin
                    if (decide) begin
                        shreg   <= {bit_val, shreg[MAX_BITS-1:1]};
                        par_acc <= par_acc ^ bit_val;
                    end
                    if (bit_end) begin
                        if (idx == last_idx) state <= parity_en ? RX_PARITY : RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (decide)  par_bit <= bit_val;
                    if (bit_end) state   <= RX_STOP;
                end
                RX_STOP: begin
                    if (decide) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign done      = enable && (state == RX_STOP) && decide;
    assign done_data = shreg >> shift_amt;
    assign done_ferr = !bit_val;
    assign done_perr = parity_en && (par_acc ^ par_bit ^ parity_odd);

endmodule

// File: rtl/uart_rx_varlen.sv
// Top of the serial receiver: synchronizer, bit timer, frame controller
// and the one-entry receive buffer with its ready and error flags.
// Assumes: os_tick is a one-cycle pulse, OVERSAMPLE pulses per bit.
module uart_rx_varlen #(
    parameter int OVERSAMPLE  = 16,
    parameter int MIN_BITS    = 5,
    parameter int MAX_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    rx_en,
    input  logic                                    rx_line,
    input  logic                                    os_tick,
    input  logic [$clog2(MAX_BITS-MIN_BITS+1)-1:0]  word_len,
    input  logic                                    parity_en,
    input  logic                                    parity_odd,
    input  logic                                    rd_stb,
    output logic [MAX_BITS-1:0]                     rd_data,
    output logic                                    rx_ready,
    output logic                                    err_frame,
    output logic                                    err_parity
);

    logic                line_s;
    logic                decide;
    logic                bit_end;
    logic                bit_val;
    logic                timer_run;
    logic                rx_busy;
    logic                frame_done;
    logic [MAX_BITS-1:0] frame_data;
    logic                frame_ferr;
    logic                frame_perr;

    rxv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    rxv_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .run     (timer_run),
        .line    (line_s),
        .decide  (decide),
        .bit_end (bit_end),
        .bit_val (bit_val)
    );

    rxv_frame_ctrl #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .tick       (os_tick),
        .line       (line_s),
        .word_len   (word_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .decide     (decide),
        .bit_end    (bit_end),
        .bit_val    (bit_val),
        .timer_run  (timer_run),
        .busy       (rx_busy),
        .done       (frame_done),
        .done_data  (frame_data),
        .done_ferr  (frame_ferr),
        .done_perr  (frame_perr)
    );

    // Receive buffer: load on frame completion, clear ready on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= '0;
            rx_ready   <= 1'b0;
            err_frame  <= 1'b0;
            err_parity <= 1'b0;
        end else if (frame_done) begin
            rd_data    <= frame_data;
            rx_ready   <= 1'b1;
            err_frame  <= frame_ferr;
            err_parity <= frame_perr;
        end else if (rd_stb) begin
            rx_ready   <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_varlen_chk.sv
// Property checker for the serial receiver, attached by bind.
// Assumes: connected to the top-level ports plus the frame-done and busy nets.
module uart_rx_varlen_chk #(
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 8
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    os_tick,
    input logic                                    rx_en,
    input logic                                    rd_stb,
    input logic                                    parity_en,
    input logic [$clog2(MAX_BITS-MIN_BITS+1)-1:0]  word_len,
    input logic [MAX_BITS-1:0]                     rd_data,
    input logic                                    rx_ready,
    input logic                                    err_frame,
    input logic                                    err_parity,
    input logic                                    frame_done,
    input logic                                    rx_busy
);

    AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(os_tick) && $past(rx_en));  // R6

    AST_OUT_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> $stable(rd_data) && $stable(err_frame) && $stable(err_parity));  // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !os_tick |=> !rx_ready);  // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> ((rd_data >> (MIN_BITS + int'($past(word_len)))) == '0));  // R7

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_busy);  // R9

    AST_NO_PARITY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !parity_en |=> !err_parity);  // R4

endmodule

bind uart_rx_varlen uart_rx_varlen_chk #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .rx_en      (rx_en),
    .rd_stb     (rd_stb),
    .parity_en  (parity_en),
    .word_len   (word_len),
    .rd_data    (rd_data),
    .rx_ready   (rx_ready),
    .err_frame  (err_frame),
    .err_parity (err_parity),
    .frame_done (frame_done),
    .rx_busy    (rx_busy)
);

// File: tb/uart_rx_varlen_test.sv
// Bench for the serial receiver. The line is a queue of one-strobe segments.
// A behavioural model turns each frame start into its completion strobe and
// compares every output on every clock.
module uart_rx_varlen_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    typedef struct packed { logic v; logic first; } seg_t;
    typedef struct packed { logic expect_it; logic [7:0] data; logic ferr; logic perr; int off; } rec_t;
    typedef struct packed { int target; logic [7:0] data; logic ferr; logic perr; } pend_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rx_ready;
    logic       err_frame;
    logic       err_parity;

    seg_t  segq[$];
    rec_t  recq[$];
    pend_t pendq[$];

    int   n_checks = 0;
    int   n_fail = 0;
    int   tk = 0;
    int   cyc = 0;
    bit   finished = 0;
    bit   rd_req = 0;
    bit   rd_on_done = 0;
    logic       exp_ready = 1'b0;
    logic [7:0] exp_data = 8'h00;
    logic       exp_ferr = 1'b0;
    logic       exp_perr = 1'b0;

    uart_rx_varlen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .rx_line    (rx_line),
        .os_tick    (os_tick),
        .word_len   (word_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .rx_ready   (rx_ready),
        .err_frame  (err_frame),
        .err_parity (err_parity)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, want, $time);
        end
    endtask

    // Model and line driver: update expectations per edge, compare, drive next inputs
    initial begin : engine
        logic  e_tick;
        logic  e_rd;
        bit    hit;
        seg_t  s;
        rec_t  r;
        pend_t p;
        forever begin
            @(posedge clk);
            e_tick = os_tick;
            e_rd   = rd_stb;
            hit    = 0;
            if (e_tick) begin
                if (rst_n && pendq.size() > 0 && pendq[0].target == tk) begin
                    exp_ready = 1'b1;
                    exp_data  = pendq[0].data;
                    exp_ferr  = pendq[0].ferr;
                    exp_perr  = pendq[0].perr;
                    void'(pendq.pop_front());
                    hit = 1;
                end
                tk++;
            end
            if (!rst_n) begin
                exp_ready = 1'b0; exp_data = 8'h00; exp_ferr = 1'b0; exp_perr = 1'b0;
            end else if (e_rd && !hit) begin
                exp_ready = 1'b0;
            end
            @(negedge clk);
            check("R6 R8 R10 rx_ready", {31'd0, rx_ready}, {31'd0, exp_ready});
            check("R2 R7 rd_data", {24'd0, rd_data}, {24'd0, exp_data});
            check("R5 err_frame", {31'd0, err_frame}, {31'd0, exp_ferr});
            check("R4 err_parity", {31'd0, err_parity}, {31'd0, exp_perr});
            if (e_tick) begin
                if (segq.size() > 0) begin
                    s = segq.pop_front();
                    rx_line = s.v;
                    if (s.first) begin
                        r = recq.pop_front();
                        if (r.expect_it) begin
                            p.target = tk + r.off;
                            p.data = r.data; p.ferr = r.ferr; p.perr = r.perr;
                            pendq.push_back(p);
                        end
                    end
                end else begin
                    rx_line = 1'b1;
                end
            end
            cyc++;
            os_tick = ((cyc % TICK_DIV) == 0);
            rd_stb = 1'b0;
            if (rd_req) begin
                rd_stb = 1'b1;
                rd_req = 0;
            end
            if (rd_on_done && os_tick && pendq.size() > 0 && pendq[0].target == tk) begin
                rd_stb = 1'b1;
                rd_on_done = 0;
            end
        end
    end

    task automatic push_segs(input logic v, input int count, input bit mark_first, input bit noisy);
        seg_t s;
        for (int k = 0; k < count; k++) begin
            s.v = v ^ (noisy && k == 8);
            s.first = mark_first && (k == 0);
            segq.push_back(s);
        end
    endtask

    // Build a frame on the line and record its expected result
    task automatic send_frame(input logic [7:0] d, input int n, input bit pe, input bit po,
                              input bit bad_par, input bit bad_stop, input bit noisy,
                              input bit expect_it, input int gap);
        rec_t r;
        logic [8:0] mask;
        logic [7:0] m;
        logic       p;
        mask = (9'd1 << n) - 9'd1;
        m = d & mask[7:0];
        p = (^m) ^ po ^ bad_par;
        word_len   = 2'(n - 5);
        parity_en  = pe;
        parity_odd = po;
        r.expect_it = expect_it;
        r.data = m;
        r.ferr = bad_stop;
        r.perr = pe && bad_par;
        r.off  = 16 * (1 + n + (pe ? 1 : 0)) + 9;
        recq.push_back(r);
        push_segs(1'b0, 16, 1, 0);
        for (int i = 0; i < n; i++) push_segs(d[i], 16, 0, noisy);
        if (pe) push_segs(p, 16, 0, 0);
        push_segs(!bad_stop, 16, 0, 0);
        if (gap > 0) push_segs(1'b1, gap, 0, 0);
    endtask

    task automatic wait_idle();
        while (segq.size() != 0 || pendq.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic do_read();
        rd_req = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Stimulus sequence
    initial begin : stim
        repeat (4) @(negedge clk);
        check("R10 reset ready", {31'd0, rx_ready}, 32'd0);
        check("R10 reset data", {24'd0, rd_data}, 32'd0);
        check("R10 reset errors", {30'd0, err_frame, err_parity}, 32'd0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        // R2 eight bits, LSB first
        send_frame(8'hA5, 8, 0, 0, 0, 0, 0, 1, 20);
        wait_idle();
        check("R2 8-bit word", {24'd0, rd_data}, 32'hA5);
        check("R6 ready after load", {31'd0, rx_ready}, 32'd1);
        do_read();
        check("R8 ready cleared by read", {31'd0, rx_ready}, 32'd0);
        check("R8 data kept after read", {24'd0, rd_data}, 32'hA5);

        // R7 five bits: upper bits read as zero
        send_frame(8'hFF, 5, 0, 0, 0, 0, 0, 1, 20);
        wait_idle();
        check("R7 5-bit mask", {24'd0, rd_data}, 32'h1F);
        send_frame(8'hEA, 6, 0, 0, 0, 0, 0, 1, 20);
        wait_idle();
        check("R7 6-bit mask", {24'd0, rd_data}, 32'h2A);

        // R4 parity, even and odd, good and bad
        send_frame(8'hDB, 7, 1, 0, 0, 0, 0, 1, 20);
        wait_idle();
        check("R4 even parity ok", {31'd0, err_parity}, 32'd0);
        check("R4 7-bit data", {24'd0, rd_data}, 32'h5B);
        send_frame(8'h3C, 8, 1, 1, 0, 0, 0, 1, 20);
        wait_idle();
        check("R4 odd parity ok", {31'd0, err_parity}, 32'd0);
        send_frame(8'h3D, 8, 1, 1, 1, 0, 0, 1, 20);
        wait_idle();
        check("R4 odd parity mismatch", {31'd0, err_parity}, 32'd1);
        send_frame(8'h11, 6, 1, 0, 1, 0, 0, 1, 20);
        wait_idle();
        check("R4 even parity mismatch", {31'd0, err_parity}, 32'd1);

        // R5 low stop bit: error flagged, word still loaded
        send_frame(8'h6E, 8, 0, 0, 0, 1, 0, 1, 24);
        wait_idle();
        check("R5 frame error", {31'd0, err_frame}, 32'd1);
        check("R5 data loaded", {24'd0, rd_data}, 32'h6E);

        // R3 one flipped centre sample per data bit
        send_frame(8'h96, 8, 0, 0, 0, 0, 1, 1, 20);
        wait_idle();
        check("R3 majority vote", {24'd0, rd_data}, 32'h96);

        // R1 short low pulse is a false start
        do_read();
        push_segs(1'b0, 4, 0, 0);
        push_segs(1'b1, 24, 0, 0);
        wait_idle();
        check("R1 false start ignored", {31'd0, rx_ready}, 32'd0);
        check("R1 data unchanged", {24'd0, rd_data}, 32'h96);
        send_frame(8'h42, 8, 0, 0, 0, 0, 0, 1, 20);
        wait_idle();
        check("R1 valid start after glitch", {24'd0, rd_data}, 32'h42);

        // R6 back-to-back frames, no second stop bit
        send_frame(8'h15, 7, 0, 0, 0, 0, 0, 1, 0);
        send_frame(8'h6A, 7, 0, 0, 0, 0, 0, 1, 20);
        wait_idle();
        check("R6 back-to-back second word", {24'd0, rd_data}, 32'h6A);

        // R8 read on the loading edge keeps ready set
        check("R8 ready before same-edge read", {31'd0, rx_ready}, 32'd1);
        send_frame(8'hC3, 8, 0, 0, 0, 0, 0, 1, 20);
        rd_on_done = 1;
        wait_idle();
        check("R8 load wins over read", {31'd0, rx_ready}, 32'd1);
        check("R8 new word", {24'd0, rd_data}, 32'hC3);
        do_read();

        // R9 disabled: frame ignored
        rx_en = 1'b0;
        send_frame(8'h00, 8, 0, 0, 0, 0, 0, 0, 20);
        wait_idle();
        check("R9 disabled no load", {31'd0, rx_ready}, 32'd0);
        check("R9 disabled data kept", {24'd0, rd_data}, 32'hC3);
        rx_en = 1'b1;

        // R9 disable in mid-frame drops the frame
        send_frame(8'h0F, 8, 0, 0, 0, 0, 0, 0, 20);
        while (segq.size() > 80) @(negedge clk);
        rx_en = 1'b0;
        wait_idle();
        rx_en = 1'b1;
        repeat (8) @(negedge clk);
        check("R9 aborted no load", {31'd0, rx_ready}, 32'd0);
        check("R9 aborted data kept", {24'd0, rd_data}, 32'hC3);
        send_frame(8'h5A, 8, 0, 0, 0, 0, 0, 1, 20);
        wait_idle();
        check("R9 receives after re-enable", {24'd0, rd_data}, 32'h5A);

        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule